// File: doc/BRIEF.md
# Infrared Pulse Timing Capture

This block times the pulses coming out of a demodulated infrared or UHF receiver. The raw receiver line is brought into the clock domain, optionally inverted, and then sampled on a tick that a programmable divider derives from the system clock. Every duration is counted in ticks. Each symbol yields two figures: the time the carrier is present (the mark), and the full period from the start of that mark to the start of the next one. Software recovers the space as period minus mark.

Finished symbols go into a small FIFO, which a host drains through a register window of eight words. A symbol train is closed by timeout: when no new mark starts within a programmed number of ticks, the open symbol is written out with a last-symbol flag. Four interrupt sources, each behind its own mask bit, are combined onto one interrupt line.

Top module: `ir_symbol_capture`

## Requirements
- R1: Sampling happens on a tick that fires once every DIV clocks (register 1). A DIV of 0 behaves like 1. All durations are counted in ticks.
- R2: A mark starts on a tick where the conditioned input is high and was low on the previous tick. The mark count is the number of consecutive high ticks from that start. The period count is the number of ticks from one mark start to the next. Register 6 reads the head entry's period and register 7 reads its mark. Both read 0 when the FIFO is empty.
- R3: CTRL (register 0) bit 1 inverts the synchronised input before measurement, so a low level is then treated as carrier present.
- R4: CTRL bit 0 enables capture. While it is 0, no symbol is written and any open symbol is abandoned.
- R5: Register 2 sets the maximum period (0 turns the timeout off). If an open symbol reaches that many period ticks without a new mark, it is written with period equal to that value and with the last flag set, and interrupt status bit 1 is set.
- R6: The FIFO holds 8 entries in arrival order. Interrupt status bit 3 reads 1 while it is full.
- R7: A symbol that completes while the FIFO is full is dropped and sets overrun status bit 2. Bit 2 stays set until a 1 is written to it in register 4. Writing a 1 to bit 1 there clears the last flag in the same way, and a new setting event wins over a clear in the same cycle.
- R8: Interrupt status (register 4) has bit 0 = FIFO not empty, bit 1 = last symbol, bit 2 = overrun and bit 3 = full. Register 3 holds the mask. The irq output is the OR of status AND mask.
- R9: Mark and period counters stop at 65535 and do not wrap.
- R10: Register 5 reads bit 0 = FIFO not empty, bit 1 = head entry is a last symbol, and bits 7:4 = entry count. Reading register 7 pops one entry. Reading register 6 pops nothing.
- R11: After reset, CTRL, the maximum period, the mask and the status all read 0, DIV reads 1, the FIFO is empty and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Demodulated receiver line, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of register 7 pops the FIFO) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
Assertions check four things on every cycle: tick spacing when the divider is stable, that a mark never exceeds its period, that no symbol comes out while capture is off, and the relation between FIFO occupancy, the full flag, the sticky overrun and last flags, and period reads that do not pop. Exact tick counts, the timeout value, the polarity inversion, the drop policy on overflow, the saturation values and entry order can only be seen by driving pulse trains. The bench compares these against its cycle-by-cycle model and against hand-computed values.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  typedef enum logic [2:0] {
    REG_CTRL     = 3'd0,
    REG_DIV      = 3'd1,
    REG_MAXPER   = 3'd2,
    REG_IRQEN    = 3'd3,
    REG_IRQSTAT  = 3'd4,
    REG_FIFOSTAT = 3'd5,
    REG_PERIOD   = 3'd6,
    REG_MARK     = 3'd7
  } reg_addr_e;

  localparam int IRQ_DATA = 0;
  localparam int IRQ_LAST = 1;
  localparam int IRQ_OVR  = 2;
  localparam int IRQ_FULL = 3;
  localparam int IRQ_NUM  = 4;
  localparam int FSTAT_CNT_LSB = 4;
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;

  function automatic logic [DW-1:0] tick_limit(input logic [DW-1:0] d);
    return (d == '0) ? '0 : d - DW'(1);
  endfunction

  assign lim  = tick_limit(div);
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + DW'(1);
  end

  // R1: with a stable divider above 1, two ticks never come back to back
  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/ir_edge_meter.sv
module ir_edge_meter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_async,
  input  logic          invert,
  input  logic          enable,
  input  logic          tick,
  input  logic [CW-1:0] max_per,
  output logic          sym_valid,
  output logic          sym_last,
  output logic [CW-1:0] sym_period,
  output logic [CW-1:0] sym_mark
);
  logic          sync1, sync2, lvl, prev_lvl;
  logic          active, in_mark;
  logic [CW-1:0] per_cnt, mark_cnt;
  logic          mark_start, timeout_hit;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (&v) ? v : v + CW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= rx_async;
      sync2 <= sync1;
    end
  end

  assign lvl         = sync2 ^ invert;
  assign mark_start  = tick && lvl && !prev_lvl;
  assign timeout_hit = tick && enable && active && !mark_start &&
                       (max_per != '0) && (per_cnt >= max_per);
  assign sym_valid   = tick && enable && active && (mark_start || timeout_hit);
  assign sym_last    = timeout_hit;
  assign sym_period  = per_cnt;
  assign sym_mark    = mark_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= 1'b0;
    else if (tick) prev_lvl <= lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      in_mark  <= 1'b0;
      per_cnt  <= '0;
      mark_cnt <= '0;
    end else if (!enable) begin
      active <= 1'b0;
    end else if (tick) begin
      if (mark_start) begin
        active   <= 1'b1;
        in_mark  <= 1'b1;
        per_cnt  <= CW'(1);
        mark_cnt <= CW'(1);
      end else if (active) begin
        if (timeout_hit) begin
          active <= 1'b0;
        end else begin
          per_cnt <= sat_inc(per_cnt);
          if (in_mark && lvl) mark_cnt <= sat_inc(mark_cnt);
          if (!lvl) in_mark <= 1'b0;
        end
      end
    end
  end

  // R2: a mark can never outlast the period it belongs to
  a_r2_mark_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> (sym_mark <= sym_period));
  // R4: once capture is off, the next cycle emits no symbol
  a_r4_off_no_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sym_valid);
endmodule

// File: rtl/ir_sym_fifo.sv
module ir_sym_fifo #(
  parameter int DW    = 33,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   din,
  input  logic            pop,
  output logic [DW-1:0]   dout,
  output logic [CNTW-1:0] count,
  output logic            full,
  output logic            empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CNTW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNTW'(1);
        2'b01:   count <= count - CNTW'(1);
        default: count <= count;
      endcase
    end
  end

  // R6: occupancy never exceeds the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));
  // R6: a full FIFO stays full until something is popped
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
endmodule

// File: rtl/ir_symbol_capture.sv
module ir_symbol_capture
  import ir_cap_pkg::*;
#(
  parameter int CW    = 16,
  parameter int DEPTH = 8,
  localparam int FW   = 2 * CW + 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);
  logic                ctrl_en, ctrl_inv;
  logic [CW-1:0]       div_r, maxper_r;
  logic [IRQ_NUM-1:0]  irq_en, irq_stat, stat_clr;
  logic                st_last, st_ovr;
  logic                tick;
  logic                sym_valid, sym_last;
  logic [CW-1:0]       sym_period, sym_mark;
  logic [FW-1:0]       head;
  logic [CNTW-1:0]     fifo_count;
  logic                fifo_full, fifo_empty, fifo_pop;
  logic                ovr_evt, clr_wr;
  logic                head_last;
  logic [CW-1:0]       head_per, head_mark, fstat;

  ir_tick_gen #(.DW(CW)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_r), .tick(tick)
  );

  ir_edge_meter #(.CW(CW)) u_meter (
    .clk(clk), .rst_n(rst_n), .rx_async(rx_in), .invert(ctrl_inv),
    .enable(ctrl_en), .tick(tick), .max_per(maxper_r),
    .sym_valid(sym_valid), .sym_last(sym_last),
    .sym_period(sym_period), .sym_mark(sym_mark)
  );

  ir_sym_fifo #(.DW(FW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(sym_valid),
    .din({sym_last, sym_period, sym_mark}), .pop(fifo_pop),
    .dout(head), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  assign fifo_pop  = bus_rd && (bus_addr == REG_MARK);
  assign ovr_evt   = sym_valid && fifo_full;
  assign clr_wr    = bus_wr && (bus_addr == REG_IRQSTAT);
  assign stat_clr  = clr_wr ? bus_wdata[IRQ_NUM-1:0] : '0;
  assign head_last = head[FW-1] && !fifo_empty;
  assign head_per  = fifo_empty ? '0 : head[2*CW-1:CW];
  assign head_mark = fifo_empty ? '0 : head[CW-1:0];

  always_comb begin
    irq_stat           = '0;
    irq_stat[IRQ_DATA] = !fifo_empty;
    irq_stat[IRQ_LAST] = st_last;
    irq_stat[IRQ_OVR]  = st_ovr;
    irq_stat[IRQ_FULL] = fifo_full;
  end

  assign irq = |(irq_stat & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_inv <= 1'b0;
      div_r    <= CW'(1);
      maxper_r <= '0;
      irq_en   <= '0;
      st_last  <= 1'b0;
      st_ovr   <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == REG_CTRL) begin
        ctrl_en  <= bus_wdata[0];
        ctrl_inv <= bus_wdata[1];
      end
      if (bus_wr && bus_addr == REG_DIV)    div_r    <= bus_wdata;
      if (bus_wr && bus_addr == REG_MAXPER) maxper_r <= bus_wdata;
      if (bus_wr && bus_addr == REG_IRQEN)  irq_en   <= bus_wdata[IRQ_NUM-1:0];
      st_last <= sym_last || (st_last && !stat_clr[IRQ_LAST]);
      st_ovr  <= ovr_evt  || (st_ovr  && !stat_clr[IRQ_OVR]);
    end
  end

  always_comb begin
    fstat                         = '0;
    fstat[0]                      = !fifo_empty;
    fstat[1]                      = head_last;
    fstat[FSTAT_CNT_LSB +: CNTW]  = fifo_count;
  end

  always_comb begin
    case (bus_addr)
      REG_CTRL:     bus_rdata = {{(CW-2){1'b0}}, ctrl_inv, ctrl_en};
      REG_DIV:      bus_rdata = div_r;
      REG_MAXPER:   bus_rdata = maxper_r;
      REG_IRQEN:    bus_rdata = {{(CW-IRQ_NUM){1'b0}}, irq_en};
      REG_IRQSTAT:  bus_rdata = {{(CW-IRQ_NUM){1'b0}}, irq_stat};
      REG_FIFOSTAT: bus_rdata = fstat;
      REG_PERIOD:   bus_rdata = head_per;
      default:      bus_rdata = head_mark;
    endcase
  end

  // R7: overrun stays set unless its clear bit is written
  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovr && !(clr_wr && bus_wdata[IRQ_OVR])) |=> st_ovr);
  // R5: a timeout close raises the last-symbol status
  a_r5_timeout_flags: assert property (@(posedge clk) disable iff (!rst_n)
    sym_last |=> st_last);
  // R10: a period read never lowers the occupancy
  a_r10_period_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_PERIOD) |=> (fifo_count >= $past(fifo_count)));
endmodule

// File: tb/ir_symbol_capture_bench.sv
`timescale 1ns/1ps
module ir_symbol_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ir_symbol_capture u_ir_symbol_capture (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_s1, m_s2, m_prev, m_active, m_inmark, m_per, m_mark, m_dcnt;
  int m_en, m_inv, m_div, m_maxper, m_irqen, m_last, m_ovr;
  longint q[$];

  function automatic int sat(int v);
    return (v >= 65535) ? 65535 : v + 1;
  endfunction

  function automatic int m_stat();
    int s = 0;
    if (q.size() != 0) s |= 1;
    if (m_last != 0)   s |= 2;
    if (m_ovr != 0)    s |= 4;
    if (q.size() == 8) s |= 8;
    return s;
  endfunction

  function automatic int m_rd(int a);
    case (a)
      0: return (m_inv << 1) | m_en;
      1: return m_div;
      2: return m_maxper;
      3: return m_irqen;
      4: return m_stat();
      5: return (q.size() << 4) | ((q.size() != 0 && q[0][32]) ? 2 : 0) | (q.size() != 0 ? 1 : 0);
      6: return (q.size() != 0) ? int'(q[0][31:16]) : 0;
      default: return (q.size() != 0) ? int'(q[0][15:0]) : 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R3";
      1: return "R1";
      2: return "R5";
      3: return "R8";
      4: return "R7";
      5: return "R10";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_active = 0; m_inmark = 0;
      m_per = 0; m_mark = 0; m_dcnt = 0; m_en = 0; m_inv = 0; m_div = 1;
      m_maxper = 0; m_irqen = 0; m_last = 0; m_ovr = 0;
      q.delete();
    end else begin
      int lvl, lim, clr;
      bit tick, rise, to, valid, was_full, do_pop;
      lvl = m_s2 ^ m_inv;
      lim = (m_div == 0) ? 0 : m_div - 1;
      tick = (m_dcnt >= lim);
      rise = tick && lvl != 0 && m_prev == 0;
      to = tick && m_en != 0 && m_active != 0 && !rise && m_maxper != 0 && m_per >= m_maxper;
      valid = tick && m_en != 0 && m_active != 0 && (rise || to);
      was_full = (q.size() == 8);
      do_pop = bus_rd && bus_addr == 3'd7 && q.size() != 0;
      if (do_pop) void'(q.pop_front());
      if (valid && !was_full)
        q.push_back((longint'(to) << 32) | (longint'(m_per) << 16) | longint'(m_mark));
      clr = (bus_wr && bus_addr == 3'd4) ? int'(bus_wdata) : 0;
      m_last = (to || (m_last != 0 && (clr & 2) == 0)) ? 1 : 0;
      m_ovr  = ((valid && was_full) || (m_ovr != 0 && (clr & 4) == 0)) ? 1 : 0;
      if (m_en == 0) m_active = 0;
      else if (tick) begin
        if (rise) begin
          m_active = 1; m_inmark = 1; m_per = 1; m_mark = 1;
        end else if (m_active != 0) begin
          if (to) m_active = 0;
          else begin
            m_per = sat(m_per);
            if (m_inmark != 0 && lvl != 0) m_mark = sat(m_mark);
            if (lvl == 0) m_inmark = 0;
          end
        end
      end
      if (tick) m_prev = lvl;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin m_en = bus_wdata[0]; m_inv = bus_wdata[1]; end
          3'd1: m_div = bus_wdata;
          3'd2: m_maxper = bus_wdata;
          3'd3: m_irqen = bus_wdata[3:0];
          default: ;
        endcase
      end
      m_dcnt = tick ? 0 : m_dcnt + 1;
      m_s2 = m_s1;
      m_s1 = rx_in;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_of(int'(bus_addr)), int'(bus_rdata), m_rd(int'(bus_addr)));
      chk("R8 irq", int'(irq), ((m_stat() & m_irqen) != 0) ? 1 : 0);
    end
  end

  // ---------------- stimulus tasks (all leave time at negedge+1) --------
  task automatic wr(int a, int d);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    bus_rd = 1'b1; bus_addr = 3'(a);
    #1 v = int'(bus_rdata);
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    int v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic hold(bit v, int n);
    rx_in = v;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // R11 reset state
    rd_chk("R11 ctrl", 0, 0);
    rd_chk("R11 div", 1, 1);
    rd_chk("R11 maxper", 2, 0);
    rd_chk("R11 irqstat", 4, 0);
    rd_chk("R11 fifostat", 5, 0);
    chk("R11 irq", int'(irq), 0);

    // R2 R10 R8: basic capture, divider 1, no timeout
    wr(3, 1);
    wr(0, 1);
    idle(4);
    hold(1, 3); hold(0, 7);
    hold(1, 5); hold(0, 5);
    hold(1, 2); hold(0, 10);
    hold(1, 1); hold(0, 20);
    rd_chk("R10 count three", 5, 'h31);
    chk("R8 data irq", int'(irq), 1);
    rd_chk("R2 period first", 6, 10);
    rd_chk("R10 period read keeps", 5, 'h31);
    rd_chk("R2 mark first", 7, 3);
    rd_chk("R10 mark read pops", 5, 'h21);
    rd_chk("R2 period second", 6, 10);
    rd_chk("R2 mark second", 7, 5);
    rd_chk("R2 period third", 6, 12);
    rd_chk("R2 mark third", 7, 2);
    wr(0, 0);
    rd_chk("R2 empty reads zero", 6, 0);

    // R5: timeout closes the train
    wr(2, 20);
    wr(3, 2);
    wr(0, 1);
    idle(4);
    hold(1, 4); hold(0, 6);
    hold(1, 3); hold(0, 40);
    rd_chk("R5 two entries", 5, 'h21);
    rd_chk("R5 last status", 4, 3);
    chk("R5 last irq", int'(irq), 1);
    rd_chk("R5 normal mark", 7, 4);
    rd_chk("R5 head is last", 5, 'h13);
    rd_chk("R5 period equals limit", 6, 20);
    wr(4, 2);
    rd_chk("R7 last cleared", 4, 1);
    chk("R8 masked irq", int'(irq), 0);
    rd_chk("R5 last mark", 7, 3);
    wr(0, 0);
    wr(2, 0);

    // R3: inverted polarity
    hold(1, 4);
    wr(0, 3);
    idle(4);
    hold(0, 6); hold(1, 4);
    hold(0, 2); hold(1, 8);
    hold(0, 1); hold(1, 10);
    rd_chk("R3 inverted period", 6, 10);
    rd_chk("R3 inverted mark", 7, 6);
    rd_chk("R3 inverted mark two", 7, 2);
    wr(0, 0);
    hold(0, 6);

    // R1: divider of four
    wr(1, 4);
    wr(0, 1);
    idle(8);
    hold(1, 8);  hold(0, 32);
    hold(1, 12); hold(0, 28);
    hold(1, 4);  hold(0, 8);
    hold(1, 4);  hold(0, 12);
    rd_chk("R1 three entries", 5, 'h31);
    rd_chk("R1 period in ticks", 6, 10);
    rd_chk("R1 mark in ticks", 7, 2);
    rd_chk("R1 mark two", 7, 3);
    rd_chk("R1 short period", 6, 3);
    rd_chk("R1 short mark", 7, 1);
    wr(0, 0);
    wr(1, 0);
    idle(4);

    // R6 R7: fill and overrun (divider 0 acts as 1)
    wr(3, 'hC);
    wr(0, 1);
    idle(4);
    for (int i = 0; i < 11; i++) begin
      hold(1, 2); hold(0, 4);
    end
    wr(0, 0);
    rd_chk("R6 fifo holds eight", 5, 'h81);
    rd_chk("R7 overrun and full", 4, 'hD);
    chk("R6 full irq", int'(irq), 1);
    wr(4, 4);
    rd_chk("R7 overrun cleared", 4, 9);
    rd_chk("R1 div zero period", 6, 6);
    for (int i = 0; i < 8; i++) rd_chk("R6 drained mark", 7, 2);
    rd_chk("R6 empty status", 4, 0);
    chk("R8 irq low", int'(irq), 0);

    // R4: disabled capture ignores pulses
    for (int i = 0; i < 3; i++) begin
      hold(1, 2); hold(0, 4);
    end
    rd_chk("R4 nothing captured", 5, 0);

    // R9: saturation
    wr(1, 1);
    wr(0, 1);
    idle(4);
    hold(1, 70000); hold(0, 10);
    hold(1, 1); hold(0, 5);
    rd_chk("R9 period saturates", 6, 65535);
    rd_chk("R9 mark saturates", 7, 65535);
    wr(0, 0);
    idle(3);

    finish_run();
  end
endmodule